// File: doc/BRIEF.md
# Complementary Dead-Time Gate Driver Controller

This block turns a single pulse-width-modulated control level into two complementary gate-drive signals for a half-bridge. `drv_hi` switches the high-side transistor and `drv_lo` switches the low-side transistor. Whenever the driven side changes, both outputs are held low for a programmable number of clock cycles before the newly selected output is allowed to rise. The two outputs are never high together.

Before the control level reaches the dead-time logic, it passes a minimum-pulse-width qualifier, so short glitches are dropped. A global disable and two per-channel lockout inputs, for example from supply monitors, pull outputs low within the same clock cycle. When a forcing input is released, a full dead-time interval runs again before any output rises. Everything runs in one clock domain, and dead time is counted in clock cycles.

Top module: `dtg_halfbridge`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled, both outputs are low.
- R2: In steady state, `drv_hi` is high and `drv_lo` is low when the accepted PWM level is 1. When the accepted level is 0, `drv_lo` is high and `drv_hi` is low.
- R3: When the accepted level changes, the active output falls on the next clock edge. The other output rises exactly N+1 edges later, so both outputs are low for N+1 cycles. N is `dt_set` when `dt_min` is 0.
- R4: `dt_set` = 0 and `dt_min` = 1 (whatever `dt_set` holds) both give the minimum gap of exactly one cycle with both outputs low.
- R5: `drv_hi` and `drv_lo` are never high in the same cycle, under any sequence of inputs.
- R6: If the accepted level reverses while a gap is being counted, the count restarts for the new target. The previously active output stays low until that restarted count completes.
- R7: While `disable_in` is high, both outputs are low, starting in the same cycle it rises. After release, the output that matches the accepted level rises on the (N+1)-th edge after the last edge that sampled `disable_in` high.
- R8: `lock_hi` forces only `drv_hi` low, and `lock_lo` forces only `drv_lo` low, with the same immediate drop and the same release timing as R7.
- R9: A new PWM level is accepted only once `pwm_in` has held it for MIN_PW consecutive clock edges (default 2). Shorter pulses leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM control level, 1 selects the high side |
| dt_set | input | DT_W | Dead time in clock cycles (N) |
| dt_min | input | 1 | When high, forces the minimum dead time (N = 0) |
| disable_in | input | 1 | Active-high disable, forces both outputs low |
| lock_hi | input | 1 | High-side channel lockout, forces `drv_hi` low |
| lock_lo | input | 1 | Low-side channel lockout, forces `drv_lo` low |
| drv_hi | output | 1 | High-side gate drive |
| drv_lo | output | 1 | Low-side gate drive |

## Verification
A `pwm_in` change reaches the dead-time logic MIN_PW-1 edges after it is first sampled. The active output then drops one edge later, and the opposite output rises N+1 edges after that. Disable and lockout act combinationally on the outputs, while their release is counted from the last edge that saw them high. The bench drives inputs a quarter period after each rising edge. It advances a behavioural model on the rising edge and compares both outputs at every falling edge, so each due cycle is checked exactly where it falls. Directed gap measurements count the number of both-low cycles, and a same-cycle probe checks the immediate drop on disable.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Which output the controller is currently driving (before force gating).
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;

endpackage

// File: rtl/dtg_glitch_filt.sv
module dtg_glitch_filt #(
  parameter int MIN_PW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  output logic lvl_q
);

  generate
    if (MIN_PW <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= pwm_in;
      end
    end else begin : g_count
      localparam int CW = $clog2(MIN_PW);
      localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          lvl_q <= 1'b0;
          run_q <= '0;
        end else if (pwm_in == lvl_q) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          lvl_q <= pwm_in;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  // R9
  filt_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ($past(pwm_in) == lvl_q));

endmodule

// File: rtl/dtg_gap_ctrl.sv
module dtg_gap_ctrl
  import dtg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic            force_hi,
  input  logic            force_lo,
  input  logic [DT_W-1:0] dt_n,
  output logic            hi_q,
  output logic            lo_q
);

  side_e           drv_q;
  logic            tgt_q;
  logic [DT_W-1:0] cnt_q;
  logic            tgt_forced;

  assign tgt_forced = lvl ? force_hi : force_lo;
  assign hi_q = (drv_q == SIDE_HI);
  assign lo_q = (drv_q == SIDE_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= SIDE_NONE;
      tgt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tgt_q <= lvl;
      case (drv_q)
        SIDE_HI: begin
          if (!lvl || force_hi) begin
            drv_q <= SIDE_NONE;
            cnt_q <= '0;
          end
        end
        SIDE_LO: begin
          if (lvl || force_lo) begin
            drv_q <= SIDE_NONE;
            cnt_q <= '0;
          end
        end
        default: begin
          if (tgt_forced || (lvl != tgt_q)) begin
            cnt_q <= '0;
          end else if (cnt_q >= dt_n) begin
            drv_q <= lvl ? SIDE_HI : SIDE_LO;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  hi_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> !$past(lo_q));
  // R5
  lo_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> !$past(hi_q));
  // R2
  hi_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> $past(lvl));
  // R2
  lo_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> !$past(lvl));
  // R7
  forced_hi_chk: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> !hi_q);
  // R8
  forced_lo_chk: assert property (@(posedge clk) disable iff (rst)
    force_lo |=> !lo_q);

endmodule

// File: rtl/dtg_out_gate.sv
module dtg_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic hi_q,
  input  logic lo_q,
  input  logic force_hi,
  input  logic force_lo,
  output logic out_hi,
  output logic out_lo
);

  assign out_hi = hi_q & ~force_hi;
  assign out_lo = lo_q & ~force_lo;

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_hi && out_lo));

endmodule

// File: rtl/dtg_halfbridge.sv
module dtg_halfbridge #(
  parameter int DT_W   = 8,
  parameter int MIN_PW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dt_set,
  input  logic            dt_min,
  input  logic            disable_in,
  input  logic            lock_hi,
  input  logic            lock_lo,
  output logic            drv_hi,
  output logic            drv_lo
);

  logic            lvl;
  logic            hi_q;
  logic            lo_q;
  logic            force_hi;
  logic            force_lo;
  logic [DT_W-1:0] dt_n;

  assign force_hi = disable_in | lock_hi;
  assign force_lo = disable_in | lock_lo;
  assign dt_n     = dt_min ? '0 : dt_set;

  dtg_glitch_filt #(.MIN_PW(MIN_PW)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .lvl_q  (lvl)
  );

  dtg_gap_ctrl #(.DT_W(DT_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .force_hi (force_hi),
    .force_lo (force_lo),
    .dt_n     (dt_n),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
  );

  dtg_out_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .force_hi (force_hi),
    .force_lo (force_lo),
    .out_hi   (drv_hi),
    .out_lo   (drv_lo)
  );

endmodule

// File: tb/sim_dtg_halfbridge.sv
module sim_dtg_halfbridge;

  localparam int PER    = 10;
  localparam int DT_W   = 8;
  localparam int MIN_PW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            pwm_in = 1'b0;
  logic [DT_W-1:0] dt_set = 8'd3;
  logic            dt_min = 1'b0;
  logic            disable_in = 1'b0;
  logic            lock_hi = 1'b0;
  logic            lock_lo = 1'b0;
  logic            drv_hi;
  logic            drv_lo;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_hi = 0, m_lo = 0, m_lvl = 0, m_prev = 0, m_last = 0;
  int m_since = 0, m_run = 0;

  always #(PER/2) clk = ~clk;

  dtg_halfbridge #(.DT_W(DT_W), .MIN_PW(MIN_PW)) u0 (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .dt_set(dt_set), .dt_min(dt_min),
    .disable_in(disable_in), .lock_hi(lock_hi), .lock_lo(lock_lo),
    .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // Behavioural model: one update per rising edge from the inputs held there.
  always @(posedge clk) begin
    if (rst) begin
      m_hi = 0; m_lo = 0; m_lvl = 0; m_prev = 0; m_last = 0;
      m_since = 0; m_run = 0;
    end else begin
      int  n;
      bit  fh, fl, tgt_blocked;
      n  = dt_min ? 0 : int'(dt_set);
      fh = disable_in | lock_hi;
      fl = disable_in | lock_lo;
      tgt_blocked = m_lvl ? fh : fl;
      if (m_hi) begin
        if (fh || !m_lvl) begin m_hi = 0; m_since = 0; end
      end else if (m_lo) begin
        if (fl || m_lvl) begin m_lo = 0; m_since = 0; end
      end else if (tgt_blocked || (m_lvl != m_prev)) begin
        m_since = 0;
      end else if (m_since >= n) begin
        if (m_lvl) m_hi = 1; else m_lo = 1;
      end else begin
        m_since++;
      end
      m_prev = m_lvl;
      if (pwm_in == m_last) m_run++; else m_run = 1;
      m_last = pwm_in;
      if (m_run >= MIN_PW) m_lvl = pwm_in;
    end
  end

  // Compare at every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit eh, el;
      eh = m_hi & ~(disable_in | lock_hi);
      el = m_lo & ~(disable_in | lock_lo);
      vectors++;
      if (drv_hi !== eh || drv_lo !== el) begin
        miscompares++;
        $display("FAIL %s: drv_hi=%b drv_lo=%b expected %b %b at %0t",
                 cur_req, drv_hi, drv_lo, eh, el, $time);
      end
      vectors++;
      if (drv_hi === 1'b1 && drv_lo === 1'b1) begin // R5
        miscompares++;
        $display("FAIL R5: both outputs high, actual 11 expected not 11 at %0t", $time);
      end
    end
  end

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #(PER/4);
  endtask

  task automatic check(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Count the both-low cycles between the fall of one output and the rise of the other.
  task automatic gap_check(input string tag, input int expect_gap);
    int low = 0;
    int guard = 0;
    bit seen = 0;
    while (guard < 600) begin
      @(negedge clk);
      guard++;
      if (!drv_hi && !drv_lo) begin low++; seen = 1; end
      else if (seen) break;
    end
    vectors++;
    if (low != expect_gap) begin
      miscompares++;
      $display("FAIL %s: gap actual %0d expected %0d", tag, low, expect_gap);
    end
    tick(1);
  endtask

  initial begin
    #(PER*200000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(5);
    check("R1", drv_hi | drv_lo, 1'b0);
    rst = 1'b0;
    tick(1);
    check("R1", drv_hi | drv_lo, 1'b0);
    tick(10);
    cur_req = "R2";
    check("R2", drv_lo, 1'b1);
    check("R2", drv_hi, 1'b0);

    // R3: gap of N+1 with N = 3
    cur_req = "R3";
    pwm_in = 1'b1;
    gap_check("R3", 4);
    tick(3);
    check("R2", drv_hi, 1'b1);
    pwm_in = 1'b0;
    gap_check("R3", 4);
    tick(3);
    dt_set = 8'd20;
    pwm_in = 1'b1;
    gap_check("R3", 21);
    tick(3);

    // R4: minimum dead time
    cur_req = "R4";
    dt_set = 8'd0;
    pwm_in = 1'b0;
    gap_check("R4", 1);
    tick(3);
    dt_set = 8'd9;
    dt_min = 1'b1;
    pwm_in = 1'b1;
    gap_check("R4", 1);
    tick(3);
    dt_min = 1'b0;
    dt_set = 8'd6;
    pwm_in = 1'b0;
    tick(20);

    // R6: reversal inside a running gap
    cur_req = "R6";
    pwm_in = 1'b1;
    tick(5);
    pwm_in = 1'b0;
    begin
      bit hi_seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (drv_hi) hi_seen = 1;
      end
      tick(1);
      check("R6", hi_seen, 1'b0);
      check("R6", drv_lo, 1'b1);
    end

    // R7: disable
    cur_req = "R7";
    dt_set = 8'd2;
    pwm_in = 1'b1;
    tick(15);
    check("R7", drv_hi, 1'b1);
    disable_in = 1'b1;
    #1;
    check("R7", drv_hi | drv_lo, 1'b0);
    tick(5);
    check("R7", drv_hi | drv_lo, 1'b0);
    disable_in = 1'b0;
    tick(10);
    check("R7", drv_hi, 1'b1);

    // R8: per-channel lockout
    cur_req = "R8";
    lock_lo = 1'b1;
    tick(4);
    check("R8", drv_hi, 1'b1);
    lock_lo = 1'b0;
    lock_hi = 1'b1;
    #1;
    check("R8", drv_hi, 1'b0);
    tick(6);
    lock_hi = 1'b0;
    tick(8);
    check("R8", drv_hi, 1'b1);
    pwm_in = 1'b0;
    tick(10);
    lock_lo = 1'b1;
    #1;
    check("R8", drv_lo, 1'b0);
    tick(3);
    lock_lo = 1'b0;
    tick(10);
    check("R8", drv_lo, 1'b1);

    // R9: glitch rejection
    cur_req = "R9";
    pwm_in = 1'b1;
    tick(1);
    pwm_in = 1'b0;
    tick(12);
    check("R9", drv_lo, 1'b1);
    check("R9", drv_hi, 1'b0);
    pwm_in = 1'b1;
    tick(2);
    pwm_in = 1'b0;
    tick(20);

    // R5: random stress, model compared every cycle
    cur_req = "R5";
    begin
      int hold = 0, dhold = 0, lh = 0, ll = 0;
      for (int i = 0; i < 5000; i++) begin
        if (hold == 0) begin
          pwm_in = ~pwm_in;
          hold = 1 + int'($urandom_range(0, 25));
        end else hold--;
        if (dhold > 0) dhold--;
        else if ($urandom_range(0, 99) < 2) dhold = 1 + int'($urandom_range(0, 6));
        disable_in = (dhold > 0);
        if (lh > 0) lh--; else if ($urandom_range(0, 99) < 2) lh = 1 + int'($urandom_range(0, 5));
        if (ll > 0) ll--; else if ($urandom_range(0, 99) < 2) ll = 1 + int'($urandom_range(0, 5));
        lock_hi = (lh > 0);
        lock_lo = (ll > 0);
        if ($urandom_range(0, 99) < 3) begin
          dt_set = DT_W'($urandom_range(0, 7));
          dt_min = ($urandom_range(0, 3) == 0);
        end
        tick(1);
      end
    end

    tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule